// File: doc/BRIEF.md
# Memory-Mapped GPIO Port with Grouped Interrupts

This block is a general-purpose I/O port of up to 32 pins, accessed through a simple word-addressed register bus. Software sets a per-pin output value, a per-pin direction and a per-pin blink enable. The block drives the pad output value and output enable from these settings. Pad inputs pass through a two-flop synchronizer. A per-pin polarity bit can then invert them. The result is the data-in word that software reads.

Each pin can raise an interrupt in two ways. In edge mode, a 0-to-1 transition of the polarity-adjusted input latches a cause bit, and that bit stays set until software clears it. In level mode, the polarity-adjusted input itself is the request. Each pin's request is enabled by its own edge mask bit and level mask bit. The pin requests are OR-reduced in groups of eight onto four interrupt lines.

A free-running square wave gates the output of every pin that has blink enabled. The half-period of this wave is a parameter. Writes use `bus_sel` and `bus_we` and take effect on the next clock edge. Reads are combinational from `bus_addr`. An internal synchronizer releases the block's reset two clock edges after `rst_n` rises.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset, the direction word reads as all ones over the implemented pins, so every `pad_oe` bit is low. Every other register reads as zero, and all `irq` lines are low.
- R2: Word offsets, decoded from `bus_addr[4:2]`: 0x00 output value, 0x04 direction, 0x08 blink enable, 0x0C polarity, 0x10 data in, 0x14 edge cause, 0x18 edge mask, 0x1C level mask. Written values read back. An access with `bus_addr[1:0]` not zero is ignored on write and reads zero.
- R3: A direction bit of 0 makes the pin an output: its `pad_oe` bit is high and `pad_out` carries the output value bit. A direction bit of 1 holds `pad_oe` low.
- R4: Data in equals the pad level XOR the polarity bit. A pad change applied between clock edges first appears in data in after the second following rising edge.
- R5: An edge cause bit sets one clock edge after its polarity-adjusted input becomes visible as a 0-to-1 change. With polarity 0 this is a rising pad edge; with polarity 1 it is a falling pad edge. A 1-to-0 change of the adjusted input sets nothing.
- R6: Writing a 0 to a cause bit clears it, and writing a 1 leaves it unchanged. A new edge in the same cycle as a clearing write leaves the bit set.
- R7: The request of pin i is (data-in bit i AND level mask bit i) OR (cause bit i AND edge mask bit i). `irq[k]` is the OR of the requests of pins 8k to 8k+7, and it follows mask writes and input changes without a further register stage.
- R8: For an output pin with blink enabled, `pad_out` is the output value ANDed with a square wave that holds each level for `BLINK_HALF` clock cycles. Pins without blink keep their plain output value.
- R9: Register bits at or above `NPINS` read as zero, and an `irq` line that covers no implemented pin stays low.
- R10: Writes to the data-in offset change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write strobe, qualified by `bus_sel` |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | NPINS | Pad input levels, asynchronous |
| pad_out | output | NPINS | Pad output values |
| pad_oe | output | NPINS | Pad output enables, high means drive |
| irq | output | 4 | Grouped interrupt lines, eight pins per line |

## Verification
The bench builds the port with `NPINS` = 20 and `BLINK_HALF` = 3. With 20 pins, the sweep covers every pin in both polarities. The third line then carries a partial group of four pins, the fourth line has no pins at all, and register bits 20 to 31 must read as zero. A half-period of 3 makes many blink periods fit in a few dozen cycles, so the bench can measure the spacing between transitions directly. The sweep also times synchronizer latency and cause latching cycle by cycle, and it includes a clearing write that lands in the same cycle as a new edge.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;

  localparam int BUS_DW    = 32;
  localparam int BUS_AW    = 5;
  localparam int IRQ_LINES = 4;
  localparam int IRQ_GRP   = 8;

  typedef enum logic [2:0] {
    SEL_DOUT  = 3'd0,
    SEL_DIR   = 3'd1,
    SEL_BLINK = 3'd2,
    SEL_POL   = 3'd3,
    SEL_DIN   = 3'd4,
    SEL_CAUSE = 3'd5,
    SEL_EMASK = 3'd6,
    SEL_LMASK = 3'd7
  } reg_sel_e;

  function automatic reg_sel_e decode_sel(input logic [BUS_AW-1:0] addr);
    return reg_sel_e'(addr[BUS_AW-1:2]);
  endfunction

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb stage_d = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign rst_core_n = stage_q[1];
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stable_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= '0;
      stable_q <= '0;
    end else begin
      meta_q   <= d;
      stable_q <= meta_q;
    end
  end

  assign q = stable_q;
endmodule

// File: rtl/gpio_blink.sv
module gpio_blink #(
  parameter int HALF = 1000
) (
  input  logic clk,
  input  logic rst_n,
  output logic wave
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          wave_q, wave_d;
  logic          wrap;

  always_comb begin
    wrap   = (cnt_q == LAST);
    cnt_d  = wrap ? '0 : cnt_q + 1'b1;
    wave_d = wrap ? ~wave_q : wave_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      wave_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      wave_q <= wave_d;
    end
  end

  assign wave = wave_q;

  assert_blink_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  assert_blink_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wave_q) |-> ($past(cnt_q) == LAST));
endmodule

// File: rtl/gpio_event.sv
module gpio_event
  import gpio_ctrl_pkg::*;
#(
  parameter int W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [W-1:0]         din,
  input  logic                 cause_we,
  input  logic [W-1:0]         cause_wdata,
  input  logic [W-1:0]         emask,
  input  logic [W-1:0]         lmask,
  output logic [W-1:0]         cause,
  output logic [IRQ_LINES-1:0] irq
);
  logic [W-1:0] prev_q, prev_d;
  logic [W-1:0] cause_q, cause_d;
  logic [W-1:0] edge_vec;
  logic [W-1:0] pending;

  always_comb begin
    edge_vec = din & ~prev_q;
    prev_d   = din;
    cause_d  = (cause_we ? (cause_q & cause_wdata) : cause_q) | edge_vec;
    pending  = (din & lmask) | (cause_q & emask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      cause_q <= '0;
    end else begin
      prev_q  <= prev_d;
      cause_q <= cause_d;
    end
  end

  assign cause = cause_q;

  for (genvar g = 0; g < IRQ_LINES; g++) begin : g_line
    localparam int LO = g * IRQ_GRP;
    if (LO >= W) begin : g_empty
      assign irq[g] = 1'b0;
    end else begin : g_live
      localparam int HI = (LO + IRQ_GRP > W) ? W - 1 : LO + IRQ_GRP - 1;
      assign irq[g] = |pending[HI:LO];
    end
  end

  assert_edge_latches_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_vec) |=> ((cause_q & $past(edge_vec)) == $past(edge_vec)));

  assert_no_spurious_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((cause_q & ~$past(cause_q) & ~$past(edge_vec)) == '0));

  assert_cause_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cause_we |=> ((cause_q & $past(cause_q)) == $past(cause_q)));

  assert_masked_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (emask == '0 && lmask == '0) |-> (irq == '0));
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_ctrl_pkg::*;
#(
  parameter int NPINS      = 32,
  parameter int BLINK_HALF = 1000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_we,
  input  logic [BUS_AW-1:0]    bus_addr,
  input  logic [BUS_DW-1:0]    bus_wdata,
  output logic [BUS_DW-1:0]    bus_rdata,
  input  logic [NPINS-1:0]     pad_in,
  output logic [NPINS-1:0]     pad_out,
  output logic [NPINS-1:0]     pad_oe,
  output logic [IRQ_LINES-1:0] irq
);
  localparam int W = NPINS;

  logic rst_core_n;

  gpio_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  reg_sel_e     sel;
  logic         aligned;
  logic         wr_en;
  logic         wr_dout, wr_dir, wr_blink, wr_pol, wr_cause, wr_emask, wr_lmask;
  logic [W-1:0] wd;

  always_comb begin
    sel      = decode_sel(bus_addr);
    aligned  = (bus_addr[1:0] == 2'b00);
    wr_en    = bus_sel & bus_we & aligned;
    wr_dout  = wr_en && (sel == SEL_DOUT);
    wr_dir   = wr_en && (sel == SEL_DIR);
    wr_blink = wr_en && (sel == SEL_BLINK);
    wr_pol   = wr_en && (sel == SEL_POL);
    wr_cause = wr_en && (sel == SEL_CAUSE);
    wr_emask = wr_en && (sel == SEL_EMASK);
    wr_lmask = wr_en && (sel == SEL_LMASK);
    wd       = bus_wdata[W-1:0];
  end

  logic [W-1:0] dout_q,  dout_d;
  logic [W-1:0] dir_q,   dir_d;
  logic [W-1:0] blink_q, blink_d;
  logic [W-1:0] pol_q,   pol_d;
  logic [W-1:0] emask_q, emask_d;
  logic [W-1:0] lmask_q, lmask_d;

  always_comb begin
    dout_d  = wr_dout  ? wd : dout_q;
    dir_d   = wr_dir   ? wd : dir_q;
    blink_d = wr_blink ? wd : blink_q;
    pol_d   = wr_pol   ? wd : pol_q;
    emask_d = wr_emask ? wd : emask_q;
    lmask_d = wr_lmask ? wd : lmask_q;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      dout_q  <= '0;
      dir_q   <= '1;
      blink_q <= '0;
      pol_q   <= '0;
      emask_q <= '0;
      lmask_q <= '0;
    end else begin
      dout_q  <= dout_d;
      dir_q   <= dir_d;
      blink_q <= blink_d;
      pol_q   <= pol_d;
      emask_q <= emask_d;
      lmask_q <= lmask_d;
    end
  end

  logic [W-1:0] pin_s;
  logic [W-1:0] din;
  logic [W-1:0] cause;
  logic         blink_wave;

  gpio_sync #(.W(W)) u_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d     (pad_in),
    .q     (pin_s)
  );

  assign din = pin_s ^ pol_q;

  gpio_event #(.W(W)) u_evt (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .din         (din),
    .cause_we    (wr_cause),
    .cause_wdata (wd),
    .emask       (emask_q),
    .lmask       (lmask_q),
    .cause       (cause),
    .irq         (irq)
  );

  gpio_blink #(.HALF(BLINK_HALF)) u_blink (
    .clk   (clk),
    .rst_n (rst_core_n),
    .wave  (blink_wave)
  );

  always_comb begin
    pad_oe  = ~dir_q;
    pad_out = dout_q & ~(blink_q & {W{~blink_wave}});
  end

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      unique case (sel)
        SEL_DOUT:  bus_rdata[W-1:0] = dout_q;
        SEL_DIR:   bus_rdata[W-1:0] = dir_q;
        SEL_BLINK: bus_rdata[W-1:0] = blink_q;
        SEL_POL:   bus_rdata[W-1:0] = pol_q;
        SEL_DIN:   bus_rdata[W-1:0] = din;
        SEL_CAUSE: bus_rdata[W-1:0] = cause;
        SEL_EMASK: bus_rdata[W-1:0] = emask_q;
        SEL_LMASK: bus_rdata[W-1:0] = lmask_q;
        default:   bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: tb/sim_gpio_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_ctrl;
  localparam int NP = 20;
  localparam int HP = 3;
  localparam logic [31:0] MASK = 32'h000F_FFFF;
  localparam logic [4:0] A_DOUT = 5'h00, A_DIR = 5'h04, A_BLINK = 5'h08, A_POL = 5'h0C,
                         A_DIN = 5'h10, A_CAUSE = 5'h14, A_EMASK = 5'h18, A_LMASK = 5'h1C;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_sel, bus_we;
  logic [4:0]    bus_addr;
  logic [31:0]   bus_wdata, bus_rdata;
  logic [NP-1:0] pad_in, pad_out, pad_oe;
  logic [3:0]    irq;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  gpio_ctrl #(.NPINS(NP), .BLINK_HALF(HP)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic summary;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  logic [31:0] v, bit_p;
  logic [3:0]  grp;
  logic        prev;
  int          since, trans;

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; pad_in = '0;
    tick(3);
    rst_n = 1'b1;
    tick(3);

    // R1 reset state
    rd(A_DIR, v);   chk("R1 dir reset", v, MASK);
    rd(A_DOUT, v);  chk("R1 dout reset", v, 0);
    rd(A_BLINK, v); chk("R1 blink reset", v, 0);
    rd(A_POL, v);   chk("R1 pol reset", v, 0);
    rd(A_CAUSE, v); chk("R1 cause reset", v, 0);
    rd(A_EMASK, v); chk("R1 emask reset", v, 0);
    rd(A_LMASK, v); chk("R1 lmask reset", v, 0);
    chk("R1 oe reset", 32'(pad_oe), 0);
    chk("R1 irq reset", 32'(irq), 0);

    // R2 / R9 readback and upper bits
    wr(A_DOUT, 32'hFFFF_FFFF);   rd(A_DOUT, v);  chk("R9 dout upper zero", v, MASK);
    wr(A_BLINK, 32'hDEAD_BEEF);  rd(A_BLINK, v); chk("R2 blink readback", v, 32'hDEAD_BEEF & MASK);
    wr(A_EMASK, 32'h1234_5678);  rd(A_EMASK, v); chk("R2 emask readback", v, 32'h1234_5678 & MASK);
    wr(A_LMASK, 32'hCAFE_F00D);  rd(A_LMASK, v); chk("R2 lmask readback", v, 32'hCAFE_F00D & MASK);
    wr(A_BLINK, 0); wr(A_EMASK, 0); wr(A_LMASK, 0);
    wr(5'h01, 32'h0);            rd(A_DOUT, v);  chk("R2 misaligned write ignored", v, MASK);
    rd(5'h01, v);                chk("R2 misaligned read zero", v, 0);
    // R10 data in is read-only
    wr(A_DIN, 32'hFFFF_FFFF);    rd(A_DIN, v);   chk("R10 din write ignored", v, 0);

    // R3 direction and output drive
    wr(A_DIR, 32'h000A_5A5A); wr(A_DOUT, 32'h0001_2345);
    chk("R3 oe from dir", 32'(pad_oe), 32'h0005_A5A5);
    chk("R3 out from dout", 32'(pad_out), 32'h0001_2345);
    wr(A_DIR, 32'h0); wr(A_DOUT, 32'h000C_93F6);
    chk("R3 all outputs oe", 32'(pad_oe), MASK);
    chk("R3 out pattern", 32'(pad_out), 32'h000C_93F6);
    wr(A_DIR, 32'hFFFF_FFFF);
    chk("R3 all inputs oe", 32'(pad_oe), 0);

    // Sweep every pin in both polarities: R4 R5 R6 R7 R9
    for (int p = 0; p < NP; p++) begin
      for (int pl = 0; pl < 2; pl++) begin
        bit_p = 32'd1 << p;
        grp   = 4'd1 << (p / 8);
        wr(A_EMASK, 0); wr(A_LMASK, 0);
        pad_in = (pl != 0) ? bit_p[NP-1:0] : '0;
        wr(A_POL, (pl != 0) ? bit_p : 32'h0);
        tick(4);
        wr(A_CAUSE, 0);
        rd(A_DIN, v); chk("R4 idle reads inactive", v, 0);
        pad_in = pad_in ^ bit_p[NP-1:0];
        tick(1); rd(A_DIN, v); chk("R4 sync latency", v, 0);
        tick(1); rd(A_DIN, v); chk("R4 adjusted input", v, bit_p);
        rd(A_CAUSE, v); chk("R5 cause not yet", v, 0);
        tick(1); rd(A_CAUSE, v); chk("R5 cause set on active edge", v, bit_p);
        chk("R7 masked no irq", 32'(irq), 0);
        wr(A_EMASK, bit_p); chk("R7 R9 edge irq line", 32'(irq), 32'(grp));
        pad_in = pad_in ^ bit_p[NP-1:0];
        tick(4); chk("R7 edge irq latched", 32'(irq), 32'(grp));
        wr(A_CAUSE, 32'hFFFF_FFFF); rd(A_CAUSE, v); chk("R6 write one keeps", v, bit_p);
        wr(A_CAUSE, ~bit_p); rd(A_CAUSE, v); chk("R6 write zero clears", v, 0);
        chk("R7 irq drops after clear", 32'(irq), 0);
        wr(A_EMASK, 0); wr(A_LMASK, bit_p);
        chk("R7 level inactive", 32'(irq), 0);
        pad_in = pad_in ^ bit_p[NP-1:0];
        tick(1); chk("R7 level latency", 32'(irq), 0);
        tick(1); chk("R7 R9 level irq line", 32'(irq), 32'(grp));
        tick(1); wr(A_CAUSE, 0);
        pad_in = pad_in ^ bit_p[NP-1:0];
        tick(2); chk("R7 level released", 32'(irq), 0);
        tick(2); rd(A_CAUSE, v); chk("R5 no cause on inactive transition", v, 0);
        wr(A_LMASK, 0);
      end
    end

    // R6 new edge beats a clearing write in the same cycle
    wr(A_POL, 0); pad_in = '0; tick(4); wr(A_CAUSE, 0);
    pad_in[5] = 1'b1; tick(4);
    rd(A_CAUSE, v); chk("R6 setup pin5 latched", v, 32'h20);
    pad_in[3] = 1'b1; tick(2);
    wr(A_CAUSE, 0);
    rd(A_CAUSE, v); chk("R6 edge wins over clear", v, 32'h08);
    pad_in = '0; tick(4); wr(A_CAUSE, 0);

    // R8 blink
    wr(A_DIR, ~32'h7); wr(A_DOUT, 32'h3); wr(A_BLINK, 32'h5);
    prev = pad_out[0]; since = 0; trans = 0;
    for (int c = 0; c < 40; c++) begin
      tick(1);
      since++;
      if (pad_out[0] !== prev) begin
        if (trans > 0) chk("R8 blink half period", since, HP);
        trans++;
        since = 0;
        prev = pad_out[0];
      end
    end
    chk("R8 blink toggles seen", (trans >= 10) ? 1 : 0, 1);
    chk("R8 non-blink pin steady", 32'(pad_out[1]), 1);
    chk("R8 blink pin with zero value", 32'(pad_out[2]), 0);

    summary();
    $finish;
  end
endmodule